// File: doc/BRIEF.md
# Circular-Buffer DMA Stream Writer

This block empties one queue of 64-bit messages into a ring-shaped region of system memory. It acts as a write master on a reduced AXI4 bus that uses only the address, data and response channels, and every beat carries a full 64-bit word. The region is defined by a start offset and an exclusive end offset. Both are 128-byte aligned and measured from a global buffer base. The write pointer returns to the start as soon as it reaches the end. Software keeps the writer from overrunning unread data with a pause limit that it can move. It is told of progress by an interrupt that fires when the pointer reaches a chosen 8-byte-aligned position.

A full 16-beat burst is used when the pointer sits on a 128-byte boundary, at least 16 words are queued, and at least 128 bytes remain before the region end and before the limit. Smaller amounts of data are held for a fixed waiting time so that more words can arrive. After that time the queued words are sent as single-beat bursts. Each burst is first checked against the global base/size window. A bad target, or a bus error response, sets a sticky error flag that blocks any new burst. Configuration arrives on plain input ports. The queue storage lives outside the block and is reached through a level, a head word, a pop strobe and a flush strobe.

The controller is a five-state machine. IDLE: nothing can be sent. HOLD: fewer than 16 words are queued and the wait timer is running. ADDR: the burst address is offered. DATA: the beats are streamed. RESP: the write response is awaited. The transitions are as follows. IDLE or HOLD goes to ADDR on a launch with a good target. IDLE or HOLD goes to IDLE when the launch has a bad target or when sending is not allowed. IDLE goes to HOLD while words wait for the timer. ADDR goes to DATA on the address handshake. DATA goes to RESP on the last beat handshake. RESP goes to IDLE on the response handshake.

Top module: `ring_dma_writer`

## Requirements
- R1: After reset, m_awvalid, m_wvalid, busy, irq, irq_pending, err_addr and err_write are 0 and wr_ptr is 0.
- R2: When wr_ptr is 128-byte aligned, at least 16 words are queued, and at least 128 bytes remain before seg_end and before seg_limit, the block issues one burst with m_awlen = 15 at address buf_base + wr_ptr. The 16 queue words follow in queue order, and m_wlast is high on the 16th beat only.
- R3: With 1 to 15 words queued and the pointer aligned, no address is issued for WAIT_CYCLES (250) cycles. After that, every queued word is sent as its own burst with m_awlen = 0.
- R4: With 16 or more words queued and wr_ptr not 128-byte aligned, single-beat bursts are issued at once until the pointer is aligned, and then a full burst follows.
- R5: wr_ptr moves by the burst size in bytes only on a response handshake with m_bresp = 2'b00. When the new value equals seg_end, wr_ptr becomes seg_start.
- R6: While wr_ptr equals seg_limit, no new burst starts. Sending resumes once seg_limit holds a different value.
- R7: irq_pending is set when a completed burst moves the pointer from p to a raw value q with p < irq_point <= q, or when it wraps while irq_point equals seg_start. irq is irq_pending AND irq_stream_en AND irq_master_en. A one-cycle irq_clear pulse resets irq_pending.
- R8: If buf_size is 0, or wr_ptr plus the planned burst bytes exceeds buf_size, err_addr is set and no address is issued.
- R9: A write response with m_bresp != 2'b00 sets err_write and leaves wr_ptr unchanged.
- R10: While err_addr or err_write is set, no new burst starts. An err_clear pulse resets both flags.
- R11: A burst starts only while both dma_en and stream_en are 1. Clearing stream_en after the address handshake still lets that burst finish and advance wr_ptr.
- R12: An init_pulse sets wr_ptr to seg_start and raises fifo_flush in the same cycle.
- R13: busy rises in the cycle after the address handshake and stays high until the write response handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_base | input | ADDR_W | Global buffer base address |
| buf_size | input | ADDR_W | Global buffer size in bytes |
| seg_start | input | ADDR_W | Region start offset (128-byte aligned) |
| seg_end | input | ADDR_W | Region end offset, exclusive (128-byte aligned) |
| seg_limit | input | ADDR_W | Pause limit offset (128-byte aligned) |
| irq_point | input | ADDR_W | Interrupt pointer position (8-byte aligned) |
| dma_en | input | 1 | Master transfer enable |
| stream_en | input | 1 | Stream transfer enable |
| irq_master_en | input | 1 | Master interrupt enable |
| irq_stream_en | input | 1 | Stream interrupt enable |
| init_pulse | input | 1 | Reset pointer and flush queue |
| irq_clear | input | 1 | Clear pending interrupt |
| err_clear | input | 1 | Clear sticky errors |
| fifo_level | input | CNT_W | Words held in the queue |
| fifo_word | input | 64 | Head word of the queue |
| fifo_pop | output | 1 | Remove head word |
| fifo_flush | output | 1 | Discard all queued words |
| m_awaddr | output | ADDR_W | Burst address |
| m_awlen | output | 8 | Beats minus one |
| m_awvalid | output | 1 | Address valid |
| m_awready | input | 1 | Address ready |
| m_wdata | output | 64 | Write data |
| m_wlast | output | 1 | Last beat of burst |
| m_wvalid | output | 1 | Data valid |
| m_wready | input | 1 | Data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Response valid |
| m_bready | output | 1 | Response ready |
| wr_ptr | output | ADDR_W | Current write pointer offset |
| busy | output | 1 | Burst in flight |
| irq | output | 1 | Interrupt request |
| irq_pending | output | 1 | Sticky interrupt condition |
| err_addr | output | 1 | Sticky address error |
| err_write | output | 1 | Sticky write error |

## Verification
The bench steers the pointer onto an unaligned offset so that the change from single beats to full bursts is seen. A design that ignores alignment would issue a 16-beat burst across a 128-byte boundary, and the counts of single and full bursts would not match. The bench places the region end and the interrupt point exactly where a burst lands, which catches an off-by-one in the wrap or in the interrupt compare. It moves the limit to a value behind the pointer, where a wrong room calculation would either stall the block or let it overrun. It injects a bad response and an undersized window, drops the enable in the middle of a burst, and finishes with random queue fills under a stalling data channel, where any lost or duplicated beat shows up in the memory image or in the final pointer.

// File: rtl/rdw_pkg.sv
package rdw_pkg;
    localparam int WORD_BYTES = 8;
    localparam int WORD_LG    = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_ADDR,
        ST_DATA,
        ST_RESP
    } rdw_state_e;
endpackage

// File: rtl/rdw_plan.sv
// Burst planner: picks full or single burst and checks the global window.
module rdw_plan
    import rdw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 15,
    parameter int BURST_BEATS = 16,
    parameter int BEAT_W      = 5
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] seg_end,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic [ADDR_W-1:0] buf_size,
    input  logic [CNT_W-1:0]  level,
    input  logic              timed_out,
    output logic              full_ok,
    output logic              single_ok,
    output logic              win_bad,
    output logic [BEAT_W-1:0] beats_sel
);
    localparam int BURST_BYTES = BURST_BEATS * WORD_BYTES;
    localparam int ALIGN_LG    = $clog2(BURST_BYTES);

    logic [ADDR_W-1:0] room_end;
    logic [ADDR_W-1:0] room_lim;
    logic [ADDR_W:0]   reach;
    logic              aligned;
    logic              enough;

    always_comb begin
        aligned   = (ptr[ALIGN_LG-1:0] == '0);
        room_end  = seg_end - ptr;
        room_lim  = (seg_limit > ptr) ? (seg_limit - ptr) : room_end;
        enough    = (level >= CNT_W'(BURST_BEATS));
        full_ok   = aligned && enough
                    && (room_end >= ADDR_W'(BURST_BYTES))
                    && (room_lim >= ADDR_W'(BURST_BYTES));
        single_ok = (level != '0) && (enough || timed_out);
        beats_sel = full_ok ? BEAT_W'(BURST_BEATS) : BEAT_W'(1);
        reach     = {1'b0, ptr} + ((ADDR_W+1)'(beats_sel) << WORD_LG);
        win_bad   = (buf_size == '0) || (reach > {1'b0, buf_size});
    end
endmodule

// File: rtl/rdw_track.sv
// Pointer, wrap, interrupt flag and sticky error flags.
module rdw_track
    import rdw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic [ADDR_W-1:0] seg_start,
    input  logic [ADDR_W-1:0] seg_end,
    input  logic [ADDR_W-1:0] irq_point,
    input  logic              adv,
    input  logic [ADDR_W-1:0] adv_bytes,
    input  logic              irq_clear,
    input  logic              err_clear,
    input  logic              addr_fault,
    input  logic              resp_fault,
    output logic [ADDR_W-1:0] ptr,
    output logic              irq_pend,
    output logic              err_addr,
    output logic              err_write
);
    logic [ADDR_W-1:0] raw;
    logic              wrap;
    logic              hit;

    always_comb begin
        raw  = ptr + adv_bytes;
        wrap = (raw >= seg_end);
        hit  = adv && (((irq_point > ptr) && (irq_point <= raw))
                       || (wrap && (irq_point == seg_start)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr       <= '0;
            irq_pend  <= 1'b0;
            err_addr  <= 1'b0;
            err_write <= 1'b0;
        end else begin
            if (init) begin
                ptr <= seg_start;
            end else if (adv) begin
                ptr <= wrap ? seg_start : raw;
            end
            irq_pend  <= hit | (irq_pend & ~irq_clear);
            err_addr  <= addr_fault | (err_addr & ~err_clear);
            err_write <= resp_fault | (err_write & ~err_clear);
        end
    end

    // R5
    ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr[WORD_LG-1:0] == '0);

    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear && !adv) |=> !irq_pend);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_addr && !err_clear) |=> err_addr);
endmodule

// File: rtl/ring_dma_writer.sv
module ring_dma_writer
    import rdw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 15,
    parameter int BURST_BEATS = 16,
    parameter int WAIT_CYCLES = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] buf_base,
    input  logic [ADDR_W-1:0] buf_size,
    input  logic [ADDR_W-1:0] seg_start,
    input  logic [ADDR_W-1:0] seg_end,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic [ADDR_W-1:0] irq_point,
    input  logic              dma_en,
    input  logic              stream_en,
    input  logic              irq_master_en,
    input  logic              irq_stream_en,
    input  logic              init_pulse,
    input  logic              irq_clear,
    input  logic              err_clear,
    input  logic [CNT_W-1:0]  fifo_level,
    input  logic [63:0]       fifo_word,
    output logic              fifo_pop,
    output logic              fifo_flush,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic [7:0]        m_awlen,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [63:0]       m_wdata,
    output logic              m_wlast,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic [1:0]        m_bresp,
    input  logic              m_bvalid,
    output logic              m_bready,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              busy,
    output logic              irq,
    output logic              irq_pending,
    output logic              err_addr,
    output logic              err_write
);
    localparam int BEAT_W = $clog2(BURST_BEATS + 1);
    localparam int TMR_W  = $clog2(WAIT_CYCLES + 1);

    rdw_state_e        state, state_nx;
    logic [TMR_W-1:0]  tmr;
    logic [BEAT_W-1:0] beats_q, beat_cnt, beats_sel;
    logic [ADDR_W-1:0] awaddr_q;
    logic              fresh, busy_q;
    logic              full_ok, single_ok, win_bad, timed_out;
    logic              idle_like, go_ok, launch, last_beat, resp_hs, resp_bad;

    assign timed_out = (tmr == TMR_W'(WAIT_CYCLES));
    assign idle_like = (state == ST_IDLE) || (state == ST_HOLD);
    assign go_ok     = dma_en && stream_en && !err_addr && !err_write
                       && (wr_ptr != seg_limit) && (fifo_level != '0);
    assign launch    = idle_like && go_ok && (full_ok || single_ok);
    assign last_beat = (beat_cnt == beats_q - 1'b1);
    assign resp_hs   = (state == ST_RESP) && m_bvalid;
    assign resp_bad  = (m_bresp != 2'b00);

    rdw_plan #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_BEATS(BURST_BEATS), .BEAT_W(BEAT_W)
    ) plan_i (
        .ptr(wr_ptr), .seg_end(seg_end), .seg_limit(seg_limit), .buf_size(buf_size),
        .level(fifo_level), .timed_out(timed_out), .full_ok(full_ok),
        .single_ok(single_ok), .win_bad(win_bad), .beats_sel(beats_sel)
    );

    rdw_track #(.ADDR_W(ADDR_W)) track_i (
        .clk(clk), .rst_n(rst_n), .init(init_pulse), .seg_start(seg_start),
        .seg_end(seg_end), .irq_point(irq_point),
        .adv(resp_hs && !resp_bad && fresh),
        .adv_bytes(ADDR_W'(beats_q) << WORD_LG),
        .irq_clear(irq_clear), .err_clear(err_clear),
        .addr_fault(launch && win_bad), .resp_fault(resp_hs && resp_bad),
        .ptr(wr_ptr), .irq_pend(irq_pending), .err_addr(err_addr), .err_write(err_write)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_HOLD: begin
                if (launch && !win_bad) state_nx = ST_ADDR;
                else if (!launch && go_ok) state_nx = ST_HOLD;
                else state_nx = ST_IDLE;
            end
            ST_ADDR: if (m_awready) state_nx = ST_DATA;
            ST_DATA: if (m_wready && last_beat) state_nx = ST_RESP;
            ST_RESP: if (m_bvalid) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Burst bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr      <= '0;
            beats_q  <= BEAT_W'(1);
            beat_cnt <= '0;
            awaddr_q <= '0;
            fresh    <= 1'b0;
            busy_q   <= 1'b0;
        end else begin
            if (init_pulse || (idle_like && fifo_level == '0)) begin
                tmr <= '0;
            end else if (idle_like && go_ok && !launch && !timed_out) begin
                tmr <= tmr + 1'b1;
            end
            if (launch && !win_bad) begin
                beats_q  <= beats_sel;
                beat_cnt <= '0;
                awaddr_q <= buf_base + wr_ptr;
                fresh    <= 1'b1;
            end else begin
                if (state == ST_DATA && m_wready) beat_cnt <= beat_cnt + 1'b1;
                if (init_pulse) fresh <= 1'b0;
            end
            if (m_awvalid && m_awready) busy_q <= 1'b1;
            else if (resp_hs)           busy_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        m_awvalid   = (state == ST_ADDR);
        m_awaddr    = awaddr_q;
        m_awlen     = 8'(beats_q - 1'b1);
        m_wvalid    = (state == ST_DATA);
        m_wdata     = fifo_word;
        m_wlast     = (state == ST_DATA) && last_beat;
        m_bready    = (state == ST_RESP);
        fifo_pop    = m_wvalid && m_wready;
        fifo_flush  = init_pulse;
        busy        = busy_q;
        irq         = irq_pending && irq_stream_en && irq_master_en;
    end

    // R13
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(m_awvalid && m_awready));

    // R10
    err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_awvalid) |-> !$past(err_addr || err_write));

    // R6
    limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_awvalid) |-> $past(wr_ptr != seg_limit));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(m_bvalid && m_bready) && !init_pulse) |=> $stable(wr_ptr));

    // R2
    aw_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));
endmodule

// File: tb/ring_dma_writer_tb_top.sv
`timescale 1ns/1ps
module ring_dma_writer_tb_top;
    localparam logic [31:0] BASE  = 32'h8000_0000;
    localparam logic [31:0] SIZE  = 32'h0001_0000;
    localparam logic [31:0] START = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [31:0] buf_size = SIZE, seg_end = 32'h2000, seg_limit = 32'h0F80;
    logic [31:0] irq_point = 32'hFFF8;
    logic dma_en = 0, stream_en = 0, irq_master_en = 0, irq_stream_en = 0;
    logic init_pulse = 0, irq_clear = 0, err_clear = 0;
    logic [14:0] fifo_level;
    logic [63:0] fifo_word;
    logic fifo_pop, fifo_flush;
    logic [31:0] m_awaddr;
    logic [7:0]  m_awlen;
    logic m_awvalid, m_awready = 1'b1, m_wlast, m_wvalid, m_wready = 1'b1, m_bready;
    logic [63:0] m_wdata;
    logic [1:0]  m_bresp = 2'b00, inj_resp = 2'b00;
    logic m_bvalid = 1'b0;
    logic [31:0] wr_ptr;
    logic busy, irq, irq_pending, err_addr, err_write;

    ring_dma_writer dut_i (
        .clk(clk), .rst_n(rst_n), .buf_base(BASE), .buf_size(buf_size),
        .seg_start(START), .seg_end(seg_end), .seg_limit(seg_limit),
        .irq_point(irq_point), .dma_en(dma_en), .stream_en(stream_en),
        .irq_master_en(irq_master_en), .irq_stream_en(irq_stream_en),
        .init_pulse(init_pulse), .irq_clear(irq_clear), .err_clear(err_clear),
        .fifo_level(fifo_level), .fifo_word(fifo_word), .fifo_pop(fifo_pop),
        .fifo_flush(fifo_flush), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_wdata(m_wdata),
        .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
        .wr_ptr(wr_ptr), .busy(busy), .irq(irq), .irq_pending(irq_pending),
        .err_addr(err_addr), .err_write(err_write)
    );

    // Queue model
    logic [63:0] fq [0:1023];
    int unsigned hd = 0, tl = 0, seq = 0;
    assign fifo_level = 15'(tl - hd);
    assign fifo_word  = fq[hd % 1024];
    always @(posedge clk) begin
        if (fifo_flush) hd <= tl;
        else if (fifo_pop) hd <= hd + 1;
    end

    function automatic logic [63:0] mkword(int unsigned s);
        return {32'hD0A0_0000 ^ s, s};
    endfunction

    task automatic push(int n);
        for (int i = 0; i < n; i++) begin
            fq[tl % 1024] = mkword(seq);
            seq++;
            tl++;
        end
    endtask

    // Memory slave model
    logic [63:0] memw [logic [31:0]];
    logic [31:0] cur_addr;
    logic [7:0]  cur_len;
    int beat = 0, n_full = 0, n_single = 0, wlast_bad = 0, busy_bad = 0;
    bit rnd_mode = 0;
    always @(posedge clk) begin
        if (m_awvalid && m_awready) begin
            cur_addr <= m_awaddr;
            cur_len  <= m_awlen;
            if (m_awlen == 8'd0) n_single++;
            else if (m_awlen == 8'd15) n_full++;
        end
        if (m_wvalid && m_wready) begin
            memw[cur_addr + 32'(beat * 8)] = m_wdata;
            if (m_wlast != (beat == int'(cur_len))) wlast_bad++;
            if (!busy) busy_bad++;
            beat++;
            if (m_wlast) begin
                beat = 0;
                m_bvalid <= 1'b1;
                m_bresp  <= inj_resp;
            end
        end
        if (m_bvalid && m_bready) m_bvalid <= 1'b0;
    end
    always @(negedge clk) begin
        m_wready  <= rnd_mode ? ($urandom % 4 != 0) : 1'b1;
        m_awready <= rnd_mode ? ($urandom % 3 != 0) : 1'b1;
    end

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(int maxc);
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (fifo_level == 0 && !busy && !m_awvalid && !m_wvalid && !m_bvalid) break;
        end
        cyc(2);
    endtask

    function automatic logic [31:0] ring_adv(logic [31:0] p, int n);
        logic [31:0] q = p + 32'(n * 8);
        if (q >= seg_end) q = START + (q - seg_end);
        return q;
    endfunction

    task automatic chk_mem(string req, logic [31:0] a0, int unsigned s0, int n);
        int bad = 0;
        logic [63:0] got = '0;
        logic [31:0] a = a0;
        for (int i = 0; i < n; i++) begin
            if (!memw.exists(BASE + a) || memw[BASE + a] != mkword(s0 + i)) begin
                bad++;
                if (memw.exists(BASE + a)) got = memw[BASE + a];
            end
            a = ring_adv(a, 1);
        end
        chk(bad == 0, req, "memory image", 64'(bad), 64'd0);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        int unsigned s0;
        int aw0;
        logic [31:0] p;
        void'($urandom(32'h5EED_1234));
        cyc(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!m_awvalid && !m_wvalid && !busy && !irq && !irq_pending, "R1", "idle outputs",
            {m_awvalid, m_wvalid, busy, irq, irq_pending}, 0);
        chk(!err_addr && !err_write && wr_ptr == 0, "R1", "ptr and errors",
            {err_addr, err_write, wr_ptr}, 0);

        // R12 init flushes and resets pointer
        push(5);
        @(negedge clk); init_pulse = 1'b1; #1;
        chk(fifo_flush, "R12", "flush strobe", fifo_flush, 1);
        @(negedge clk); init_pulse = 1'b0;
        chk(wr_ptr == START && fifo_level == 0, "R12", "ptr to start, queue empty",
            {wr_ptr, 17'(fifo_level)}, {START, 17'd0});

        // R2 full burst
        dma_en = 1; stream_en = 1;
        s0 = seq; push(16); drain(400);
        chk(n_full == 1 && n_single == 0, "R2", "one full burst", {n_full, n_single}, {32'd1, 32'd0});
        chk(wlast_bad == 0, "R2", "last-beat marking", wlast_bad, 0);
        chk_mem("R2", START, s0, 16);
        chk(wr_ptr == 32'h1080, "R5", "ptr after full burst", wr_ptr, 32'h1080);

        // R3 wait then singles
        s0 = seq; aw0 = n_full + n_single; push(3);
        cyc(240);
        chk(n_full + n_single == aw0, "R3", "no request during wait", n_full + n_single, aw0);
        drain(400);
        chk(n_single == 3 && n_full == 1, "R3", "three single bursts", n_single, 3);
        chk_mem("R3", 32'h1080, s0, 3);
        chk(wr_ptr == 32'h1098, "R3", "ptr after singles", wr_ptr, 32'h1098);

        // R4 alignment: 13 singles then one full burst
        s0 = seq; push(29); drain(600);
        chk(n_single == 16 && n_full == 2, "R4", "singles to alignment then full",
            {n_single, n_full}, {32'd16, 32'd2});
        chk(wr_ptr == 32'h1180, "R4", "ptr after realign", wr_ptr, 32'h1180);
        chk_mem("R4", 32'h1098, s0, 29);

        // R5 wrap at end
        seg_end = 32'h1200;
        s0 = seq; push(16); drain(400);
        chk(wr_ptr == START, "R5", "wrap to start", wr_ptr, START);
        chk_mem("R5", 32'h1180, s0, 16);

        // R6 limit pause
        seg_limit = 32'h1080; aw0 = n_full + n_single;
        s0 = seq; push(32); cyc(600);
        chk(wr_ptr == 32'h1080 && fifo_level == 16, "R6", "paused at limit",
            {wr_ptr, 17'(fifo_level)}, {32'h1080, 17'd16});
        chk(n_full + n_single == aw0 + 1, "R6", "one burst before pause", n_full + n_single, aw0 + 1);
        seg_limit = 32'h0F80; drain(400);
        chk(wr_ptr == 32'h1100 && fifo_level == 0, "R6", "resume after limit moved", wr_ptr, 32'h1100);
        chk_mem("R6", START, s0, 32);

        // R7 interrupt
        irq_point = 32'h1140;
        push(16); drain(400);
        chk(irq_pending && !irq, "R7", "pending set, irq masked", {irq_pending, irq}, 2'b10);
        irq_stream_en = 1; @(negedge clk);
        chk(!irq, "R7", "irq needs master enable", irq, 0);
        irq_master_en = 1; @(negedge clk);
        chk(irq, "R7", "irq with both enables", irq, 1);
        pulse(irq_clear); @(negedge clk);
        chk(!irq_pending && !irq, "R7", "clear pending", {irq_pending, irq}, 0);
        irq_point = 32'h1200;
        push(16); drain(400);
        chk(irq_pending && wr_ptr == START, "R7", "hit at exact end", {irq_pending, wr_ptr}, {1'b1, START});
        pulse(irq_clear);

        // R8 / R10 address error
        buf_size = 32'h1040; aw0 = n_full + n_single;
        push(16); cyc(20);
        chk(err_addr && n_full + n_single == aw0 && wr_ptr == START, "R8", "window overrun",
            {err_addr, wr_ptr}, {1'b1, START});
        cyc(300);
        chk(n_full + n_single == aw0 && fifo_level == 16, "R10", "blocked while error", fifo_level, 16);
        buf_size = SIZE; s0 = seq - 16;
        pulse(err_clear); drain(400);
        chk(!err_addr && wr_ptr == 32'h1080, "R10", "resume after clear", {err_addr, wr_ptr}, {1'b0, 32'h1080});
        chk_mem("R10", START, s0, 16);
        buf_size = 32'h0; aw0 = n_full + n_single;
        push(16); cyc(20);
        chk(err_addr && n_full + n_single == aw0, "R8", "zero size", err_addr, 1);
        buf_size = SIZE; pulse(err_clear); drain(400);
        chk(wr_ptr == 32'h1100, "R8", "ptr after zero-size recovery", wr_ptr, 32'h1100);

        // R9 write error
        inj_resp = 2'b10;
        push(16); drain(400);
        chk(err_write && wr_ptr == 32'h1100, "R9", "bad response", {err_write, wr_ptr}, {1'b1, 32'h1100});
        inj_resp = 2'b00; aw0 = n_full + n_single;
        s0 = seq; push(16); cyc(300);
        chk(n_full + n_single == aw0, "R10", "write error blocks", n_full + n_single, aw0);
        pulse(err_clear); drain(400);
        chk(!err_write && wr_ptr == 32'h1180, "R9", "recovered ptr", wr_ptr, 32'h1180);
        chk_mem("R9", 32'h1100, s0, 16);

        // R11 enables, R13 busy window
        stream_en = 0; aw0 = n_full + n_single;
        s0 = seq; push(16); cyc(50);
        chk(n_full + n_single == aw0, "R11", "stream enable off", n_full + n_single, aw0);
        stream_en = 1; dma_en = 0; cyc(50);
        chk(n_full + n_single == aw0, "R11", "master enable off", n_full + n_single, aw0);
        dma_en = 1;
        for (int i = 0; i < 20 && !m_awvalid; i++) @(negedge clk);
        chk(!busy, "R13", "busy low before handshake", busy, 0);
        @(negedge clk);
        chk(busy, "R13", "busy after handshake", busy, 1);
        stream_en = 0;
        drain(400);
        chk(wr_ptr == START && !busy, "R11", "in-flight burst finished", wr_ptr, START);
        chk_mem("R11", 32'h1180, s0, 16);
        aw0 = n_full + n_single; push(16); cyc(50);
        chk(n_full + n_single == aw0 && wr_ptr == START, "R11", "no new burst after disable", wr_ptr, START);
        stream_en = 1; drain(400);
        chk(wr_ptr == 32'h1080, "R11", "re-enabled", wr_ptr, 32'h1080);
        chk(busy_bad == 0 && wlast_bad == 0, "R13", "busy during data beats", busy_bad, 0);

        // Random fills under stalls (R2 R3 R5)
        seg_end = 32'h2000; rnd_mode = 1;
        p = wr_ptr;
        for (int r = 0; r < 10; r++) begin
            int n = $urandom_range(1, 40);
            s0 = seq; push(n); drain(3000);
            chk_mem("R2", p, s0, n);
            p = ring_adv(p, n);
            chk(wr_ptr == p, "R5", "random round ptr", wr_ptr, p);
        end
        chk(wlast_bad == 0 && busy_bad == 0, "R2", "random beat framing", wlast_bad, 0);

        done = 1;
        report();
    end
endmodule